// File: doc/BRIEF.md
# Serial Port Pin GPIO Multiplexer

This block sits between the seven pads of a synchronous serial port and the serial core. The pads are: transmit clock, transmit frame sync, transmit data, receive clock, receive frame sync, receive data and an external clock input. A single control register is written over a simple register bus. When a section of the port is held in reset and its I/O-enable bit is set, the block hands that section's pads over to general-purpose I/O. In that case it drives the pad output and the pad output enable from register bits, and it captures pad levels into read-back bits.

A pad that is not in GPIO mode passes straight through. The pad drive and enable come from the core, and the core sees the raw pad level. The external clock pad becomes GPIO only when both sections are released to it. The transmit data pad in GPIO mode is output-only. The receive data and external clock pads in GPIO mode are input-only. Each clock and frame-sync pad takes its direction from its own mode bit.

Top module: `sp_pin_gpio_mux`

Pin index on the 7-bit pad and core vectors: 0 transmit clock, 1 transmit frame sync, 2 transmit data, 3 receive clock, 4 receive frame sync, 5 receive data, 6 external clock.

Control register bits:

| Bits | Name | Access | Meaning |
|---|---|---|---|
| 0 to 3 | mode | write/read | direction for pins 0, 1, 3, 4 (1 = output) |
| 4 to 7 | pol | write/read | level for pins 0, 1, 3, 4 |
| 8 | tx_io_en | write/read | transmit I/O enable |
| 9 | rx_io_en | write/read | receive I/O enable |
| 10 | tdat | write/read | transmit data level |
| 11 | rdat | read-only | receive data level |
| 12 | xclk | read-only | external clock level |

Bits 13 to 15 are unused.

## Requirements
- R1: After reset, rd_data reads 0 and every pad is in serial mode: pad_oe equals core_oe, pad_out equals core_out, and core_in equals pad_in.
- R2: Pins 3, 4 and 5 are GPIO exactly when rx_in_reset is 1 and bit 9 is 1. Otherwise they pass straight through to and from the core.
- R3: Pins 0, 1 and 2 are GPIO exactly when tx_in_reset is 1 and bit 8 is 1. Otherwise they pass straight through to and from the core.
- R4: Pin 6 is GPIO only when both section resets are 1 and both bits 8 and 9 are 1.
- R5: In GPIO mode, a clock or frame-sync pin is driven when its mode bit (bit 0, 1, 2 or 3) is 1, with its pol bit (bit 4, 5, 6 or 7) as the level. When its mode bit is 0 it is undriven.
- R6: In GPIO mode, pin 2 is always driven, and its level is bit 10.
- R7: In GPIO mode, pin 5 is never driven, and its synchronized level reads on bit 11.
- R8: In GPIO mode, pin 6 is never driven, and its synchronized level reads on bit 12.
- R9: A pad level reaches rd_data at the second rising clock edge after it is applied.
- R10: Writes to bits 11 and 12 have no effect. For a pin that is an input in GPIO mode, the pol bit reads the captured pad level. A pol write on such a pin is kept only as the output value, and that value shows once the pin is switched to output.
- R11: For a pin in GPIO mode, core_in is 0. Input-only GPIO pins drive pad_out 0. Outside GPIO mode, bit 11 and bit 12 read 0, and every pol bit reads its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tx_in_reset | input | 1 | transmit section held in reset |
| rx_in_reset | input | 1 | receive section held in reset |
| wr_en | input | 1 | register write strobe |
| wr_data | input | 16 | register write data |
| rd_data | output | 16 | register read data |
| pad_in | input | 7 | pad input levels |
| pad_out | output | 7 | pad output levels |
| pad_oe | output | 7 | pad output enables |
| core_out | input | 7 | serial core drive levels |
| core_oe | input | 7 | serial core drive enables |
| core_in | output | 7 | pad levels passed to the core |

## Verification
The assertions assume that the two section-reset inputs and the pad levels change only between clock edges. They also assume that the register write is one cycle wide and sampled at the rising edge. The bench drives every input at the falling edge, so each value is settled when the next rising edge samples it. The synchronizer-delay assertion also assumes that a pad level held across two edges is what the status bit should show. The bench therefore holds each pad level for at least two edges before it checks a status bit.

// File: rtl/sp_pin_pkg.sv
package sp_pin_pkg;
  localparam int NPIN  = 7;
  localparam int REG_W = 16;

  localparam int P_TCLK = 0;
  localparam int P_TFS  = 1;
  localparam int P_TDAT = 2;
  localparam int P_RCLK = 3;
  localparam int P_RFS  = 4;
  localparam int P_RDAT = 5;
  localparam int P_XCLK = 6;

  localparam int B_MODE0 = 0;
  localparam int B_POL0  = 4;
  localparam int B_TXEN  = 8;
  localparam int B_RXEN  = 9;
  localparam int B_TDAT  = 10;
  localparam int B_RDAT  = 11;
  localparam int B_XCLK  = 12;

  localparam logic [REG_W-1:0] WR_MASK = REG_W'(16'h07FF);

  // index of the mode/pol slot (0..3) for a clock or frame-sync pin
  function automatic int slot_of(input int pin);
    case (pin)
      P_TCLK: slot_of = 0;
      P_TFS:  slot_of = 1;
      P_RCLK: slot_of = 2;
      default: slot_of = 3;
    endcase
  endfunction

  function automatic logic group_gpio(input logic in_reset, input logic io_en);
    group_gpio = in_reset & io_en;
  endfunction
endpackage

// File: rtl/sp_pin_sync.sv
module sp_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sp_pin_ctrl_reg.sv
module sp_pin_ctrl_reg
  import sp_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [3:0]       slot_is_in,   // slot is a GPIO input now
  input  logic [3:0]       slot_level,   // synchronized level per slot
  input  logic             rdat_gpio,
  input  logic             rdat_level,
  input  logic             xclk_gpio,
  input  logic             xclk_level,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= (ctrl_q & ~WR_MASK) | (wr_data & WR_MASK);
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rd_data = ctrl_q & WR_MASK;
    for (int k = 0; k < 4; k++) begin
      if (slot_is_in[k]) rd_data[B_POL0+k] = slot_level[k];
    end
    rd_data[B_RDAT] = rdat_gpio & rdat_level;
    rd_data[B_XCLK] = xclk_gpio & xclk_level;
  end
endmodule

// File: rtl/sp_pin_route.sv
module sp_pin_route #(
  parameter int N = 7
) (
  input  logic [N-1:0] sel_gpio,
  input  logic [N-1:0] gpio_oe,
  input  logic [N-1:0] gpio_out,
  input  logic [N-1:0] core_oe,
  input  logic [N-1:0] core_out,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] core_in
);
  genvar p;
  generate
    for (p = 0; p < N; p++) begin : g_pin
      assign pad_oe[p]  = sel_gpio[p] ? gpio_oe[p]  : core_oe[p];
      assign pad_out[p] = sel_gpio[p] ? gpio_out[p] : core_out[p];
      assign core_in[p] = sel_gpio[p] ? 1'b0        : pad_in[p];
    end
  endgenerate
endmodule

// File: rtl/sp_pin_gpio_mux.sv
module sp_pin_gpio_mux
  import sp_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_in_reset,
  input  logic             rx_in_reset,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NPIN-1:0]  pad_in,
  output logic [NPIN-1:0]  pad_out,
  output logic [NPIN-1:0]  pad_oe,
  input  logic [NPIN-1:0]  core_out,
  input  logic [NPIN-1:0]  core_oe,
  output logic [NPIN-1:0]  core_in
);
  logic [REG_W-1:0] ctrl;
  logic [NPIN-1:0]  pad_sync;
  logic gpio_tx, gpio_rx, gpio_ck;
  logic [NPIN-1:0] sel_gpio, gpio_oe, gpio_out;
  logic [3:0] slot_is_in, slot_level;

  // named events for the checker
  assign gpio_tx = group_gpio(tx_in_reset, ctrl[B_TXEN]);
  assign gpio_rx = group_gpio(rx_in_reset, ctrl[B_RXEN]);
  assign gpio_ck = gpio_tx & gpio_rx;

  sp_pin_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  always_comb begin
    sel_gpio = '0;
    gpio_oe  = '0;
    gpio_out = '0;
    sel_gpio[P_TCLK] = gpio_tx;
    sel_gpio[P_TFS]  = gpio_tx;
    sel_gpio[P_TDAT] = gpio_tx;
    sel_gpio[P_RCLK] = gpio_rx;
    sel_gpio[P_RFS]  = gpio_rx;
    sel_gpio[P_RDAT] = gpio_rx;
    sel_gpio[P_XCLK] = gpio_ck;
    gpio_oe[P_TDAT]  = 1'b1;
    gpio_out[P_TDAT] = ctrl[B_TDAT];
    for (int p = 0; p < NPIN; p++) begin
      if (p == P_TCLK || p == P_TFS || p == P_RCLK || p == P_RFS) begin
        gpio_oe[p]  = ctrl[B_MODE0 + slot_of(p)];
        gpio_out[p] = ctrl[B_MODE0 + slot_of(p)] & ctrl[B_POL0 + slot_of(p)];
      end
    end
  end

  always_comb begin
    slot_is_in[0] = gpio_tx & ~ctrl[B_MODE0+0];
    slot_is_in[1] = gpio_tx & ~ctrl[B_MODE0+1];
    slot_is_in[2] = gpio_rx & ~ctrl[B_MODE0+2];
    slot_is_in[3] = gpio_rx & ~ctrl[B_MODE0+3];
    slot_level    = {pad_sync[P_RFS], pad_sync[P_RCLK], pad_sync[P_TFS], pad_sync[P_TCLK]};
  end

  sp_pin_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .slot_is_in(slot_is_in), .slot_level(slot_level),
    .rdat_gpio(gpio_rx), .rdat_level(pad_sync[P_RDAT]),
    .xclk_gpio(gpio_ck), .xclk_level(pad_sync[P_XCLK]),
    .ctrl(ctrl), .rd_data(rd_data)
  );

  sp_pin_route #(.N(NPIN)) u_route (
    .sel_gpio(sel_gpio), .gpio_oe(gpio_oe), .gpio_out(gpio_out),
    .core_oe(core_oe), .core_out(core_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .core_in(core_in)
  );
endmodule

// File: rtl/sp_pin_gpio_mux_chk.sv
module sp_pin_gpio_mux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_data,
  input logic [6:0]  pad_in,
  input logic [6:0]  pad_out,
  input logic [6:0]  pad_oe,
  input logic [6:0]  core_out,
  input logic [6:0]  core_oe,
  input logic [6:0]  core_in,
  input logic        gpio_tx,
  input logic        gpio_rx,
  input logic        gpio_ck
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_serial_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_tx |-> (pad_oe[2:0] == core_oe[2:0] && pad_out[2:0] == core_out[2:0]
                  && core_in[2:0] == pad_in[2:0]));
  assert_serial_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_rx |-> (pad_oe[5:3] == core_oe[5:3] && pad_out[5:3] == core_out[5:3]
                  && core_in[5:3] == pad_in[5:3]));
  assert_xclk_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_ck |-> (gpio_tx && gpio_rx));
  assert_xclk_serial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_ck |-> (pad_oe[6] == core_oe[6] && pad_out[6] == core_out[6]));
  assert_tdat_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_tx |-> (pad_oe[2] && pad_out[2] == rd_data[10]));
  assert_rdat_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_rx |-> (!pad_oe[5] && !pad_out[5] && !core_in[5]));
  assert_xclk_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_ck |-> (!pad_oe[6] && !core_in[6]));
  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && gpio_rx) |-> rd_data[11] == $past(pad_in[5], 2));
  assert_tclk_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_tx && rd_data[0]) |-> (pad_oe[0] && pad_out[0] == rd_data[4]));
  assert_core_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_tx |-> core_in[2:0] == 3'b000);
endmodule

bind sp_pin_gpio_mux sp_pin_gpio_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .core_out(core_out), .core_oe(core_oe),
  .core_in(core_in), .gpio_tx(gpio_tx), .gpio_rx(gpio_rx), .gpio_ck(gpio_ck)
);

// File: tb/sim_sp_pin_gpio_mux.sv
module sim_sp_pin_gpio_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_reset = 1'b0, rx_in_reset = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [6:0] pad_in = 7'h7F, pad_out, pad_oe;
  logic [6:0] core_out = 7'h2A, core_oe = 7'h55, core_in;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sp_pin_gpio_mux u0 (
    .clk(clk), .rst_n(rst_n), .tx_in_reset(tx_in_reset), .rx_in_reset(rx_in_reset),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in)
  );

  // {tx_rst, rx_rst, ctrl, exp_oe, exp_out, exp_core_in}; core_oe=55 core_out=2A pad_in=7F
  localparam int NV = 7;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0000, 7'h55, 7'h2A, 7'h7F},  // R1 serial
    {1'b1, 1'b0, 16'h0100, 7'h54, 7'h28, 7'h78},  // R3 tx gpio, inputs
    {1'b1, 1'b0, 16'h0513, 7'h57, 7'h2D, 7'h78},  // R5 R6 tx outputs
    {1'b0, 1'b1, 16'h034C, 7'h5D, 7'h0A, 7'h47},  // R2 R5 rx outputs, tx serial
    {1'b1, 1'b1, 16'h0300, 7'h04, 7'h00, 7'h00},  // R4 all gpio
    {1'b1, 1'b1, 16'h0200, 7'h45, 7'h02, 7'h47},  // R4 xclk needs both enables
    {1'b0, 1'b0, 16'h0300, 7'h55, 7'h2A, 7'h7F}   // R2 R3 enables without reset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data", 32'(rd_data), 32'h0);
    check("R1 pad_oe", 32'(pad_oe), 32'h55);
    check("R1 pad_out", 32'(pad_out), 32'h2A);
    check("R1 core_in", 32'(core_in), 32'h7F);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tx_in_reset = VEC[i][38];
      rx_in_reset = VEC[i][37];
      reg_write(VEC[i][36:21]);
      check($sformatf("vec%0d oe", i), 32'(pad_oe), 32'(VEC[i][20:14]));
      check($sformatf("vec%0d out", i), 32'(pad_out), 32'(VEC[i][13:7]));
      check($sformatf("vec%0d core_in", i), 32'(core_in), 32'(VEC[i][6:0]));
    end

    // R7 R9: receive data level through two edges
    tx_in_reset = 1'b1; rx_in_reset = 1'b1;
    reg_write(16'h0300);
    pad_in = 7'h00;
    repeat (3) @(negedge clk);
    check("R7 rdat low", 32'(rd_data[11]), 32'h0);
    pad_in[5] = 1'b1;
    @(negedge clk);
    check("R9 one edge", 32'(rd_data[11]), 32'h0);
    @(negedge clk);
    check("R9 R7 two edges", 32'(rd_data[11]), 32'h1);
    check("R7 never driven", 32'(pad_oe[5]), 32'h0);

    // R8 external clock level
    pad_in[6] = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 xclk status", 32'(rd_data[12]), 32'h1);
    check("R8 never driven", 32'(pad_oe[6]), 32'h0);

    // R10 read-only bits not writable
    pad_in = 7'h00;
    repeat (2) @(negedge clk);
    reg_write(16'h1B00);
    check("R10 ro bits", 32'(rd_data), 32'h0300);

    // R10 pol write on an input pin keeps captured level
    reg_write(16'h0340);
    check("R10 pol reads capture", 32'(rd_data[6]), 32'h0);
    reg_write(16'h0344);
    check("R10 pol as output oe", 32'(pad_oe[3]), 32'h1);
    check("R10 pol as output val", 32'(pad_out[3]), 32'h1);
    check("R10 pol read output", 32'(rd_data[6]), 32'h1);

    // R5 input pin reads pad level
    reg_write(16'h0300);
    pad_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 rclk capture", 32'(rd_data[6]), 32'h1);
    check("R5 rclk undriven", 32'(pad_oe[3]), 32'h0);

    // R11 outside GPIO: stored pol, status bits 0, core sees pad
    tx_in_reset = 1'b0; rx_in_reset = 1'b0;
    pad_in = 7'h7F;
    reg_write(16'h0010);
    repeat (2) @(negedge clk);
    check("R11 stored pol", 32'(rd_data), 32'h0010);
    check("R11 core_in pass", 32'(core_in), 32'h7F);
    tx_in_reset = 1'b1; rx_in_reset = 1'b1;
    reg_write(16'h0300);
    check("R11 core_in blocked", 32'(core_in), 32'h00);

    // R6 transmit data bit drives pad
    reg_write(16'h0700);
    check("R6 tdat level", 32'(pad_out[2]), 32'h1);
    check("R6 tdat oe", 32'(pad_oe[2]), 32'h1);

    // R1 reset clears again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 re-reset", 32'(rd_data), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule